// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C target that connects a two-wire serial bus to an internal space of 256 byte-wide registers. It runs entirely in the system clock domain. SCL and SDA are oversampled through synchronisers. Bus events are found by comparing each synchronised sample with the one before it. The block never drives SDA high: it only asserts an open-drain pull-down enable.

A bus master first selects the block with its 7-bit address. In a write transfer, the byte after the address loads an internal register pointer, and every later byte is written to the device side at that pointer, which then advances. A repeated START followed by a read address returns bytes starting at the stored pointer, most significant bit first, and the pointer advances after each byte. A general-call address of zero can also be accepted for writes, but only while an enable input is set. The device side sees a register address, a write data byte with a one-cycle write strobe, and a combinational read-data return.

FSM states: ST_IDLE (no transfer addressed to the block), ST_ADDR (shifting in the address byte), ST_ADDR_ACK (acknowledging the address), ST_REG (shifting in the pointer byte), ST_REG_ACK, ST_WDATA (shifting in a data byte), ST_WDATA_ACK, ST_RDATA (shifting out a data byte) and ST_RDATA_ACK (sampling the master's acknowledge). Transitions: any START goes to ST_ADDR and any STOP goes to ST_IDLE. From ST_ADDR, after eight bits, a matching address goes to ST_ADDR_ACK and any other address goes to ST_IDLE. ST_ADDR_ACK goes to ST_RDATA for a read and to ST_REG for a write. ST_REG goes to ST_REG_ACK, then ST_WDATA. ST_WDATA goes to ST_WDATA_ACK, then back to ST_WDATA. ST_RDATA goes to ST_RDATA_ACK, then back to ST_RDATA on a master ACK, or to ST_IDLE on a NACK. Every move apart from START and STOP takes place on a detected SCL falling edge.

Top module: `i2c_reg_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) begins address reception from any state. A rising SDA while SCL is high (STOP) returns the block to idle with SDA released. Bytes clocked after a STOP and without a new START are not acknowledged and cause no write.
- R2: An address byte whose upper seven bits equal DEV_ADDR is acknowledged by holding SDA low through the ninth SCL pulse. Any other non-zero address leaves SDA released.
- R3: In a write transfer, the first byte after the address is acknowledged and loaded into the register pointer shown on reg_addr, and it produces no write strobe.
- R4: Each later written byte is acknowledged. After that acknowledge, wr_stb is high for exactly one system clock, with reg_addr equal to the pointer and wr_data equal to the byte. The pointer then increases by one.
- R5: In a read transfer, the block shifts out rd_data for the current pointer MSB first, one bit per SCL pulse, and the pointer increases by one after each byte. A master ACK (SDA low in the ninth pulse) starts the next byte. A master NACK leaves SDA released until the next START.
- R6: A START during an active transfer (repeated START) returns the block to address reception and keeps the register pointer. A following read therefore starts at the pointer set by the write part.
- R7: Address 00h with the write bit (first byte 8'h00) is acknowledged and handled as a write only while gc_en is 1. With gc_en at 0, it is not acknowledged.
- R8: sda_oe changes only while the synchronised SCL is low.
- R9: After reset, sda_oe and wr_stb are 0 and reg_addr is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| gc_en | input | 1 | Accept the general-call address 00h when 1 |
| reg_addr | output | 8 | Register pointer presented to the device side |
| wr_data | output | 8 | Byte to write, valid with wr_stb |
| wr_stb | output | 1 | One-cycle register write strobe |
| rd_data | input | 8 | Register contents at reg_addr, returned combinationally |

## Verification
Single-byte writes, burst writes and reads show whether the pointer loads from the first byte and advances only after each data byte. A write that sets only the pointer, followed by a repeated START read, shows whether that pointer survives the restart. A foreign address, the zero address with the enable off and then on, and bytes clocked after a STOP with no new START show whether the block acknowledges and writes only when it should. A read ended with ACK then NACK shows both that the block continues on ACK and that it releases the line on NACK.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } slv_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic dprev
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            dprev <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            dprev <= chain[STAGES-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic scl_q,
    input  logic scl_p,
    input  logic sda_q,
    input  logic sda_p,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_held_high;

    always_comb begin
        scl_held_high = scl_q && scl_p;
        start_ev      = scl_held_high && sda_p && !sda_q;
        stop_ev       = scl_held_high && !sda_p && sda_q;
        scl_rise      = scl_q && !scl_p;
        scl_fall      = !scl_q && scl_p;
    end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_q,
    input  logic              gc_en,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_stb,
    output slv_state_t        state_o
);
    localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

    slv_state_t        state, nxt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] ptr;
    logic [3:0]        bit_cnt;
    logic              rw_bit;
    logic              master_ack;
    logic              byte_full;
    logic              addr_hit;
    logic              rx_state;

    always_comb begin
        byte_full = (bit_cnt == BITS_PER_BYTE);
        addr_hit  = (rx_sr[7:1] == DEV_ADDR) ||
                    (rx_sr[7:1] == 7'd0 && !rx_sr[0] && gc_en);
        rx_state  = (state == ST_ADDR) || (state == ST_REG) || (state == ST_WDATA);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_ev) begin
            nxt = ST_ADDR;
        end else if (stop_ev) begin
            nxt = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_full) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  nxt = rw_bit ? ST_RDATA : ST_REG;
                ST_REG:       if (byte_full) nxt = ST_REG_ACK;
                ST_REG_ACK:   nxt = ST_WDATA;
                ST_WDATA:     if (byte_full) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: nxt = ST_WDATA;
                ST_RDATA:     if (byte_full) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: nxt = master_ack ? ST_RDATA : ST_IDLE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr      <= '0;
            tx_sr      <= '0;
            ptr        <= '0;
            bit_cnt    <= '0;
            rw_bit     <= 1'b0;
            master_ack <= 1'b0;
            sda_oe     <= 1'b0;
            wr_data    <= '0;
            wr_stb     <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (wr_stb) ptr <= ptr + 8'd1;
            if (start_ev || stop_ev) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (scl_rise) begin
                if (rx_state) begin
                    rx_sr   <= {rx_sr[6:0], sda_q};
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (state == ST_RDATA) begin
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (state == ST_RDATA_ACK) begin
                    master_ack <= !sda_q;
                end
            end else if (scl_fall) begin
                unique case (state)
                    ST_ADDR: if (byte_full) begin
                        bit_cnt <= '0;
                        rw_bit  <= rx_sr[0];
                        sda_oe  <= addr_hit;
                    end
                    ST_REG: if (byte_full) begin
                        bit_cnt <= '0;
                        ptr     <= rx_sr;
                        sda_oe  <= 1'b1;
                    end
                    ST_WDATA: if (byte_full) begin
                        bit_cnt <= '0;
                        wr_data <= rx_sr;
                        sda_oe  <= 1'b1;
                    end
                    ST_ADDR_ACK: begin
                        bit_cnt <= '0;
                        if (rw_bit) begin
                            tx_sr  <= rd_data;
                            sda_oe <= !rd_data[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_REG_ACK: sda_oe <= 1'b0;
                    ST_WDATA_ACK: begin
                        sda_oe <= 1'b0;
                        wr_stb <= 1'b1;
                    end
                    ST_RDATA: begin
                        if (byte_full) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b0;
                            ptr     <= ptr + 8'd1;
                        end else begin
                            tx_sr  <= {tx_sr[6:0], 1'b0};
                            sda_oe <= !tx_sr[6];
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (master_ack) begin
                            tx_sr  <= rd_data;
                            sda_oe <= !rd_data[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_IDLE: sda_oe <= 1'b0;
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    assign reg_addr = ptr;
    assign state_o  = state;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h18,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       gc_en,
    output logic [7:0] reg_addr,
    output logic [7:0] wr_data,
    output logic       wr_stb,
    input  logic [7:0] rd_data
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw, line_q, line_p;
    logic scl_q, scl_p, sda_q, sda_p;
    logic start_ev, stop_ev, scl_rise, scl_fall;
    slv_state_t state;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (line_raw[g]),
            .dout  (line_q[g]),
            .dprev (line_p[g])
        );
    end

    assign scl_q = line_q[0];
    assign scl_p = line_p[0];
    assign sda_q = line_q[1];
    assign sda_p = line_p[1];

    i2c_cond_detect u_cond (
        .scl_q    (scl_q),
        .scl_p    (scl_p),
        .sda_q    (sda_q),
        .sda_p    (sda_p),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_q    (sda_q),
        .gc_en    (gc_en),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .wr_stb   (wr_stb),
        .state_o  (state)
    );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
    import i2c_slv_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_q,
    input logic       start_ev,
    input logic       stop_ev,
    input slv_state_t state,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic [7:0] reg_addr
);
    assert_sda_low_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_q);

    assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (reg_addr == $past(reg_addr) + 8'd1));

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_oe));

    assert_start_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_q    (scl_q),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .state    (state),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .reg_addr (reg_addr)
);

// File: tb/test_i2c_reg_slave.sv
`timescale 1ns/1ps
module test_i2c_reg_slave;
    localparam logic [6:0] DEV = 7'h18;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic gc_en = 1'b0;
    logic sda_oe, wr_stb;
    logic [7:0] reg_addr, wr_data, rd_data;
    logic [7:0] mem [256];
    logic sda_bus;
    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    assign rd_data = mem[reg_addr];

    i2c_reg_slave #(.DEV_ADDR(DEV)) i_i2c_reg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .gc_en(gc_en), .reg_addr(reg_addr), .wr_data(wr_data), .wr_stb(wr_stb),
        .rd_data(rd_data)
    );

    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    always @(posedge clk) if (wr_stb) mem[reg_addr] <= wr_data;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor for register writes
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected write strobe", {reg_addr, wr_data}, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check({reg_addr, wr_data} == e, "R4", "write addr/data", {reg_addr, wr_data}, e);
            end
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(Q);
        s = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(!give_ack, s);
    endtask

    task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    initial begin
        logic ak;
        logic [7:0] rb;
        wq(10);
        // R9 reset state
        check(sda_oe == 1'b0, "R9", "sda_oe after reset", sda_oe, 0);
        check(wr_stb == 1'b0, "R9", "wr_stb after reset", wr_stb, 0);
        check(reg_addr == 8'h00, "R9", "reg_addr after reset", reg_addr, 0);
        rst_n = 1'b1;
        wq(10);

        // R2 R3 R4: pointer then burst of two bytes
        bus_start();
        wbyte({DEV, 1'b0}, ak); check(ak, "R2", "own address ack", ak, 1);
        wbyte(8'h10, ak);       check(ak, "R3", "pointer byte ack", ak, 1);
        check(reg_addr == 8'h10, "R3", "pointer loaded", reg_addr, 8'h10);
        push_wr(8'h10, 8'h5C);
        wbyte(8'h5C, ak);       check(ak, "R4", "data ack 1", ak, 1);
        push_wr(8'h11, 8'h3E);
        wbyte(8'h3E, ak);       check(ak, "R4", "data ack 2", ak, 1);
        bus_stop();
        check(reg_addr == 8'h12, "R4", "pointer after burst", reg_addr, 8'h12);
        check(sda_oe == 1'b0, "R1", "released after stop", sda_oe, 0);

        // R5 R6: read back with repeated start, ACK then NACK
        bus_start();
        wbyte({DEV, 1'b0}, ak); check(ak, "R2", "address ack", ak, 1);
        wbyte(8'h10, ak);
        bus_start();
        wbyte({DEV, 1'b1}, ak); check(ak, "R6", "read address after rstart", ak, 1);
        rbyte(1'b1, rb);        check(rb == 8'h5C, "R5", "read byte 1", rb, 8'h5C);
        rbyte(1'b0, rb);        check(rb == 8'h3E, "R5", "read byte 2", rb, 8'h3E);
        wq(Q);
        check(sda_oe == 1'b0, "R5", "released after nack", sda_oe, 0);
        check(reg_addr == 8'h12, "R5", "pointer after two reads", reg_addr, 8'h12);
        bus_stop();

        // R6: pointer-only write kept across repeated start
        bus_start();
        wbyte({DEV, 1'b0}, ak);
        wbyte(8'h40, ak);
        bus_start();
        wbyte({DEV, 1'b1}, ak);
        rbyte(1'b0, rb);        check(rb == 8'hE5, "R6", "read at kept pointer", rb, 8'hE5);
        bus_stop();

        // R2: foreign address ignored
        bus_start();
        wbyte(8'h66, ak);       check(!ak, "R2", "foreign address nack", ak, 0);
        wbyte(8'h77, ak);       check(!ak, "R2", "following byte nack", ak, 0);
        bus_stop();
        check(reg_addr == 8'h41, "R2", "pointer untouched", reg_addr, 8'h41);

        // R7: general call
        bus_start();
        wbyte(8'h00, ak);       check(!ak, "R7", "general call disabled", ak, 0);
        bus_stop();
        gc_en = 1'b1;
        bus_start();
        wbyte(8'h00, ak);       check(ak, "R7", "general call enabled", ak, 1);
        wbyte(8'h20, ak);
        push_wr(8'h20, 8'h99);
        wbyte(8'h99, ak);       check(ak, "R7", "general call data ack", ak, 1);
        bus_stop();
        gc_en = 1'b0;

        // R1: bytes after stop without start ignored
        bus_start();
        wbyte({DEV, 1'b0}, ak);
        wbyte(8'h50, ak);
        bus_stop();
        wbyte(8'hAA, ak);       check(!ak, "R1", "byte without start nack", ak, 0);
        check(reg_addr == 8'h50, "R1", "pointer after stray byte", reg_addr, 8'h50);
        bus_stop();
        bus_start();
        wbyte({DEV, 1'b1}, ak);
        rbyte(1'b0, rb);        check(rb == 8'hF5, "R1", "register not written", rb, 8'hF5);
        bus_stop();

        wq(20);
        check(exp_q.size() == 0, "R4", "pending expected writes", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule